// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the synchronised levels of one bank of general-purpose pins, grouped as four ports of eight pins, and turns qualifying pin activity into per-pin status bits and a single bank interrupt line. Each pin has its own trigger mode: rising edge, falling edge, either edge, high level or low level. Software sets the modes and enables through a simple register bus. It reads the status and clears latched edge events by writing ones to a clear register.

Edge detection compares the present pin level with the level seen one cycle earlier. It runs whether or not the pin is enabled, so an event that arrives while a pin is masked is still recorded. A pin is pending when both its status bit and its enable bit are set. The bank interrupt is the registered OR of every pending pin in all four ports. Both the enable and the trigger-mode registers have a masked-write alias, so one pin can be changed without a read-modify-write.

Register word offsets inside a port group are: status 0x40, enable 0x50, trigger mode 0x60 and clear 0x70. Port p adds 4*p. Setting address bit 11 selects the masked alias of a register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every enable bit is 0, every trigger-mode field is 0, and the bank interrupt output is 0.
- R2: The trigger-mode register gives pin n three bits: bit n is polarity (1 = high/rising), bit 8+n selects edge mode, and bit 16+n selects both edges. The value 0x000101 per pin is rising edge. A rising edge sets the status bit, and the bit stays set after the pin falls until it is cleared.
- R3: The value 0x000100 per pin is falling edge. A falling edge sets the status bit, and a rising edge does not.
- R4: The value 0x010100 per pin is both edges. A rising edge sets the status bit, and so does a falling edge.
- R5: The value 0x000001 per pin is high level and 0x000000 is low level. In level mode the status bit follows the active level one cycle later, and a clear has no lasting effect while that level stays active.
- R6: Writing 1 to bit n of a port's clear register (offset 0x70) clears status bit n of that port. Bits written as 0 have no effect. Writes to the status register (offset 0x40) are ignored.
- R7: If a qualifying edge arrives in the same cycle as a clear of that pin, the status bit stays set.
- R8: Edges are detected while the enable bit is 0. Such a pin does not drive the interrupt.
- R9: The interrupt output is 1 exactly one cycle after some pin, in any port, has both its status bit and its enable bit set.
- R10: A write to the enable register alias (offset 0x850 + 4*port) updates only the pins whose bit is set in wdata[15:8], taking values from wdata[7:0]. A write to the plain offset 0x50 replaces all eight bits.
- R11: A write to the trigger-mode alias (offset 0x860 + 4*port) updates only the pins whose bit is set in wdata[31:24], taking the three fields from wdata[23:0]. The other pins keep their modes.
- R12: Read data is registered and shows the register addressed in the previous cycle. Status, enable and trigger read in the low bits, and the clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Synchronised pin levels, port p pin n at bit 8*p+n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Registered bank interrupt |

## Verification
The five trigger modes are each driven with both a rising and a falling pin transition. One direction must latch and the other must not, which separates rising, falling and both-edge decoding and shows whether polarity is applied in level mode. A pin edge is made to coincide with a clear write, and clears are also issued while a level stays active, to show that events are not lost and that a level cannot be cleared away. The interrupt line is observed while a pin is pending but disabled, after masked and plain enable writes, and with pending pins in different ports. A masked trigger write is read back to show that only the selected pin changed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register group selected by address bits [6:4]
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_STA  = 3'd4,
    SEL_EN   = 3'd5,
    SEL_TRIG = 3'd6,
    SEL_CLR  = 3'd7
  } reg_sel_e;

  // Per-pin trigger mode
  typedef struct packed {
    logic both;     // accept either edge
    logic is_edge;  // edge mode when 1, level mode when 0
    logic pol;      // 1: high level / rising edge
  } trig_t;

  function automatic reg_sel_e sel_of(input logic [2:0] field);
    case (field)
      3'd4:    return SEL_STA;
      3'd5:    return SEL_EN;
      3'd6:    return SEL_TRIG;
      3'd7:    return SEL_CLR;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  pin_now_i,
  input  logic  pin_prev_i,
  input  trig_t trig_i,
  input  logic  clr_i,
  output logic  sta_o
);

  logic rise, fall, evt, active;

  always_comb begin
    rise   = pin_now_i & ~pin_prev_i;
    fall   = ~pin_now_i & pin_prev_i;
    evt    = trig_i.both ? (rise | fall) : (trig_i.pol ? rise : fall);
    active = ~(pin_now_i ^ trig_i.pol);
  end

  // Edge: sticky, a new event beats a clear. Level: tracks the active level.
  always_ff @(posedge clk_i) begin
    if (rst_i)               sta_o <= 1'b0;
    else if (trig_i.is_edge) sta_o <= evt | (sta_o & ~clr_i);
    else                     sta_o <= active;
  end

endmodule

// File: rtl/gpio_irq_port_cfg.sv
module gpio_irq_port_cfg
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,   // write addressed to this port
  input  reg_sel_e            sel_i,
  input  logic                alias_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [PINS-1:0]     en_o,
  output trig_t [PINS-1:0]    trig_o
);

  logic [PINS-1:0] en_mask;
  logic [PINS-1:0] en_val;

  assign en_mask = wdata_i[2*PINS-1:PINS];
  assign en_val  = wdata_i[PINS-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_o <= '0;
    end else if (wr_en_i && sel_i == SEL_EN) begin
      if (alias_i) en_o <= (en_o & ~en_mask) | (en_val & en_mask);
      else         en_o <= en_val;
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_trig
    trig_t t_q;
    logic  take;

    assign take = wr_en_i && (sel_i == SEL_TRIG) && (!alias_i || wdata_i[3*PINS+n]);

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        t_q <= '0;
      end else if (take) begin
        t_q.pol     <= wdata_i[n];
        t_q.is_edge <= wdata_i[PINS+n];
        t_q.both    <= wdata_i[2*PINS+n];
      end
    end

    assign trig_o[n] = t_q;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 12,
  parameter int ALIAS_BIT = 11,
  parameter int DATA_W    = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic [NPORTS*PINS-1:0]    pin_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      irq_o
);

  localparam int NPINS = NPORTS * PINS;

  logic [NPINS-1:0]  pin_q;
  logic [NPINS-1:0]  sta_vec;
  logic [NPINS-1:0]  en_vec;
  logic [NPINS-1:0]  clr_vec;
  trig_t [NPINS-1:0] trig_vec;

  logic [ADDR_W-1:0] a_base;
  logic              is_alias;
  logic              addr_ok;
  logic [1:0]        port;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_d;

  // Address decode: alias bit stripped, port in [3:2], group in [6:4]
  always_comb begin
    a_base            = addr_i;
    a_base[ALIAS_BIT] = 1'b0;
  end

  assign is_alias = addr_i[ALIAS_BIT];
  assign port     = a_base[3:2];
  assign sel      = sel_of(a_base[6:4]);
  assign addr_ok  = (a_base[ADDR_W-1:7] == '0) && (a_base[1:0] == 2'b00)
                    && (int'(port) < NPORTS) && (sel != SEL_NONE);

  // Previous-cycle pin levels for edge detection
  always_ff @(posedge clk_i) pin_q <= pin_i;

  // Write-one-to-clear pulses, plain address only
  always_comb begin
    clr_vec = '0;
    for (int p = 0; p < NPORTS; p++)
      for (int n = 0; n < PINS; n++)
        clr_vec[p*PINS+n] = wr_en_i && addr_ok && !is_alias && (sel == SEL_CLR)
                            && (int'(port) == p) && wdata_i[n];
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = wr_en_i && addr_ok && (int'(port) == p);

    gpio_irq_port_cfg #(.PINS(PINS), .DATA_W(DATA_W)) cfg_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_en_i (port_wr),
      .sel_i   (sel),
      .alias_i (is_alias),
      .wdata_i (wdata_i),
      .en_o    (en_vec[p*PINS +: PINS]),
      .trig_o  (trig_vec[p*PINS +: PINS])
    );
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_pin_det det_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .pin_now_i  (pin_i[i]),
      .pin_prev_i (pin_q[i]),
      .trig_i     (trig_vec[i]),
      .clr_i      (clr_vec[i]),
      .sta_o      (sta_vec[i])
    );
  end

  // Read mux, registered
  always_comb begin
    rd_d = '0;
    if (addr_ok) begin
      for (int n = 0; n < PINS; n++) begin
        case (sel)
          SEL_STA: rd_d[n] = sta_vec[int'(port)*PINS+n];
          SEL_EN:  rd_d[n] = en_vec[int'(port)*PINS+n];
          SEL_TRIG: begin
            rd_d[n]        = trig_vec[int'(port)*PINS+n].pol;
            rd_d[PINS+n]   = trig_vec[int'(port)*PINS+n].is_edge;
            rd_d[2*PINS+n] = trig_vec[int'(port)*PINS+n].both;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_d;
      irq_o   <= |(sta_vec & en_vec);
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [NPINS-1:0]  sta,
  input logic [NPINS-1:0]  en,
  input logic [NPINS-1:0]  pin_now,
  input logic [NPINS-1:0]  pin_prev,
  input logic [NPINS-1:0]  clr,
  input trig_t [NPINS-1:0] trig
);

  logic armed_q;
  logic [NPINS-1:0] pol_m, edg_m, both_m, act_m, chg_m;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      pol_m[i]  = trig[i].pol;
      edg_m[i]  = trig[i].is_edge;
      both_m[i] = trig[i].both;
    end
    act_m = ~(pin_now ^ pol_m);
    chg_m = pin_now ^ pin_prev;
  end

  AST_EN_ZERO_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (en == '0) && !irq); // R1

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (($past(sta & edg_m & ~clr) & ~sta) == '0)); // R2

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (((sta ^ $past(act_m)) & $past(~edg_m)) == '0)); // R5

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (($past(edg_m & clr & ~chg_m) & sta) == '0)); // R6

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (($past(edg_m & both_m & chg_m) & ~sta) == '0)); // R7

  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (irq == $past(|(sta & en)))); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) chk_i (
  .clk      (clk_i),
  .rst      (rst_i),
  .irq      (irq_o),
  .sta      (sta_vec),
  .en       (en_vec),
  .pin_now  (pin_i),
  .pin_prev (pin_q),
  .clr      (clr_vec),
  .trig     (trig_vec)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;

  localparam int STA  = 'h40;
  localparam int EN   = 'h50;
  localparam int TRIG = 'h60;
  localparam int CLR  = 'h70;
  localparam int ALS  = 'h800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .pin_i   (pins),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic logic [11:0] ra(int off, int port);
    return 12'(off + 4*port);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    pins[idx] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    for (int p = 0; p < 4; p++) begin
      rd(ra(EN, p), v);
      chk("R1 enable after reset", v, 32'd0);
    end
    rd(ra(TRIG, 0), v);
    chk("R1 trigger after reset", v, 32'd0);
    rd(ra(STA, 1), v);
    chk("R5 level low with pins low", v, 32'hFF);
  endtask

  task automatic t_rising();
    logic [31:0] v;
    wr(ra(TRIG, 0), 32'h0000FFFF);
    wr(ra(CLR, 0), 32'hFF);
    rd(ra(STA, 0), v);  chk("R6 clear all", v, 32'h00);
    set_pin(3, 1'b1);
    rd(ra(STA, 0), v);  chk("R2 rising sets", v, 32'h08);
    set_pin(3, 1'b0);
    rd(ra(STA, 0), v);  chk("R2 sticky after fall", v, 32'h08);
    wr(ra(CLR, 0), 32'h00);
    rd(ra(STA, 0), v);  chk("R6 zero clear no effect", v, 32'h08);
    wr(ra(STA, 0), 32'h00);
    rd(ra(STA, 0), v);  chk("R6 status write ignored", v, 32'h08);
    wr(ra(CLR, 0), 32'h08);
    rd(ra(STA, 0), v);  chk("R6 one clears", v, 32'h00);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    pins[4] = 1'b1; wr_en = 1'b1; addr = ra(CLR, 0); wdata = 32'h10;
    @(negedge clk);
    wr_en = 1'b0;
    rd(ra(STA, 0), v);  chk("R7 edge beats clear", v, 32'h10);
    wr(ra(CLR, 0), 32'h10);
    rd(ra(STA, 0), v);  chk("R7 later clear works", v, 32'h00);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    wr(ra(TRIG, 1), 32'h0000FF00);
    wr(ra(CLR, 1), 32'hFF);
    set_pin(9, 1'b1);
    rd(ra(STA, 1), v);  chk("R3 rise ignored", v, 32'h00);
    set_pin(9, 1'b0);
    rd(ra(STA, 1), v);  chk("R3 fall sets", v, 32'h02);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    idle(2);
    chk("R8 pending but disabled", {31'd0, irq}, 32'd0);
    wr(ra(EN, 1) + ALS, 32'h0202);
    idle(2);
    chk("R9 irq on enable", {31'd0, irq}, 32'd1);
    rd(ra(EN, 1), v);  chk("R10 masked enable", v, 32'h02);
    wr(ra(EN, 1) + ALS, 32'h0101);
    rd(ra(EN, 1), v);  chk("R10 masked keeps others", v, 32'h03);
    wr(ra(EN, 1), 32'h01);
    rd(ra(EN, 1), v);  chk("R10 plain replaces", v, 32'h01);
    chk("R9 irq off when disabled", {31'd0, irq}, 32'd0);
    wr(ra(CLR, 1), 32'h02);
    wr(ra(EN, 3), 32'h80);
    idle(2);
    chk("R9 irq from port 3", {31'd0, irq}, 32'd1);
    set_pin(31, 1'b1);
    idle(3);
    chk("R9 irq drops with level", {31'd0, irq}, 32'd0);
    wr(ra(EN, 3), 32'h00);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(ra(TRIG, 2), 32'h00FFFF00);
    wr(ra(CLR, 2), 32'hFF);
    set_pin(16, 1'b1);
    rd(ra(STA, 2), v);  chk("R4 rise sets", v, 32'h01);
    wr(ra(CLR, 2), 32'h01);
    set_pin(16, 1'b0);
    rd(ra(STA, 2), v);  chk("R4 fall sets", v, 32'h01);
    wr(ra(CLR, 2), 32'h01);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(ra(TRIG, 3), 32'h000000FF);
    rd(ra(STA, 3), v);  chk("R5 level high follows", v, 32'h80);
    set_pin(26, 1'b1);
    rd(ra(STA, 3), v);  chk("R5 level high rises", v, 32'h84);
    wr(ra(CLR, 3), 32'h04);
    rd(ra(STA, 3), v);  chk("R5 clear has no lasting effect", v, 32'h84);
    set_pin(26, 1'b0);
    rd(ra(STA, 3), v);  chk("R5 level drop", v, 32'h80);
  endtask

  task automatic t_trig_mask();
    logic [31:0] v;
    wr(ra(TRIG, 2) + ALS, 32'h0200FFFF);
    rd(ra(TRIG, 2), v);  chk("R11 masked trigger", v, 32'h00FDFF02);
    wr(ra(CLR, 2), 32'hFF);
    set_pin(17, 1'b1);
    rd(ra(STA, 2), v);  chk("R11 pin now rising", v, 32'h02);
    wr(ra(CLR, 2), 32'h02);
    set_pin(17, 1'b0);
    rd(ra(STA, 2), v);  chk("R11 fall no longer counts", v, 32'h00);
  endtask

  task automatic t_latency();
    @(negedge clk);
    addr = ra(EN, 1);
    @(negedge clk);
    chk("R12 one-cycle read", rdata, 32'h01);
    addr = ra(CLR, 0);
    @(negedge clk);
    chk("R12 clear reads zero", rdata, 32'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rising();
    t_collide();
    t_falling();
    t_irq();
    t_both();
    t_level();
    t_trig_mask();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule